// File: doc/BRIEF.md
# Serial Polynomial-Multiplication Cyclic Encoder

This block produces codewords of a non-separable cyclic code by multiplying a serial data word, modulo 2, by a fixed generator polynomial. Data bits arrive one at a time, lowest-order coefficient first. Each accepted bit yields one codeword bit on the next clock. Each codeword bit is the XOR of the incoming bit with earlier inputs, picked from a short delay chain by the nonzero generator coefficients. Check information is spread through the whole codeword rather than appended at the end, so the codeword is the product polynomial itself.

A start pulse clears the delay chain and opens a word. The source then presents the data bits with a valid flag and may leave idle cycles between them. Once the last data bit is taken, the block feeds zeros into the chain on its own for as many cycles as the generator's degree. The tail of the product then drains out and the codeword reaches its full length. A done flag marks the final codeword bit. With the defaults, 11 data bits and G(X)=X^4+X^3+1 (coefficient vector 11001) give a 15-bit codeword.

Top module: `cyc_mul_enc`

## Requirements
- R1: After reset, dout, dout_valid and done are all 0.
- R2: For a data word D (bit i is the coefficient of X^i, bit 0 sent first), codeword bit j equals coefficient j of the carry-less product D(X)·G(X). G defaults to 5'b11001, where bit i is the coefficient of X^i. Codeword bits leave in order j = 0 to n-1.
- R3: Each data bit accepted on a clock edge (din_valid high, word open, start low) gives exactly one codeword bit, with dout_valid high in the cycle after that edge.
- R4: After the k-th data bit, the block emits the remaining n-k codeword bits on consecutive cycles with no further input. din and din_valid have no effect during those cycles, and each word yields exactly n valid bits.
- R5: done is high for exactly one cycle per word, together with the n-th codeword bit.
- R6: start clears the delay chain and restarts the bit count. A word that was partly fed before the start has no effect on the next codeword. No valid output follows the start edge.
- R7: While no word is open (after reset or after done), din_valid produces no output.
- R8: Idle cycles with din_valid low between data bits give no output and do not change the codeword.
- R9: When start and din_valid are both high in one cycle, the data bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the chain and opens a new word |
| din | input | 1 | Serial data bit, lowest order first |
| din_valid | input | 1 | din holds a data bit this cycle |
| dout | output | 1 | Serial codeword bit |
| dout_valid | output | 1 | dout holds a codeword bit |
| done | output | 1 | High with the last codeword bit |

## Verification
Every codeword bit is registered, so it appears one clock after the edge that accepted its data bit or its internal zero. The bench drives inputs on the falling edge and samples the outputs on the next falling edge, one clock after the edge that produced them. Flush bits follow the last data bit on consecutive cycles, and done is expected with the fifteenth valid bit. The bench collects the valid bits of each word and compares them to a carry-less product computed in the bench. It also counts the valid bits and the done pulses and records where done falls. All 2048 data words are swept, with idle gaps, junk input during the flush, and start/valid collisions varied across the sweep.

// File: rtl/cyc_mul_enc.sv
module cyc_mul_enc #(
  parameter int DATA_BITS = 11,
  parameter int DEG = 4,
  parameter logic [DEG:0] GEN = 5'b11001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  input  logic din_valid,
  output logic dout,
  output logic dout_valid,
  output logic done
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_F = CNT_W'(DEG - 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FLUSH} st_t;

  st_t state;
  logic [DEG-1:0] hist;
  logic [CNT_W-1:0] cnt;
  logic take_data, take_flush, step, in_bit, prod;

  assign take_data  = (state == S_DATA) && din_valid && !start;
  assign take_flush = (state == S_FLUSH) && !start;
  assign step       = take_data || take_flush;
  assign in_bit     = take_data & din;

  always_comb begin
    prod = GEN[0] & in_bit;
    for (int i = 1; i <= DEG; i++) prod = prod ^ (GEN[i] & hist[i-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      hist       <= '0;
      cnt        <= '0;
      dout       <= 1'b0;
      dout_valid <= 1'b0;
      done       <= 1'b0;
    end else if (start) begin
      state      <= S_DATA;
      hist       <= '0;
      cnt        <= '0;
      dout_valid <= 1'b0;
      done       <= 1'b0;
    end else begin
      dout_valid <= step;
      done       <= take_flush && (cnt == LAST_F);
      if (step) begin
        dout <= prod;
        hist <= {hist[DEG-2:0], in_bit};
      end
      if (take_data) begin
        if (cnt == LAST_D) begin
          cnt   <= '0;
          state <= S_FLUSH;
        end else cnt <= cnt + 1'b1;
      end else if (take_flush) begin
        if (cnt == LAST_F) begin
          cnt   <= '0;
          state <= S_IDLE;
        end else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module cyc_mul_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic take_data,
  input logic take_flush,
  input logic dout_valid,
  input logic done
);
  a_r3_bit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |=> dout_valid);
  a_r4_flush_emits: assert property (@(posedge clk) disable iff (!rst_n)
    take_flush |=> dout_valid);
  a_r4_flush_excludes_data: assert property (@(posedge clk) disable iff (!rst_n)
    take_flush |-> !take_data);
  a_r7_no_spurious_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_data && !take_flush) |=> !dout_valid);
  a_r6_start_mutes: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!dout_valid && !done));
  a_r5_done_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dout_valid);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cyc_mul_enc cyc_mul_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .take_data(take_data),
  .take_flush(take_flush), .dout_valid(dout_valid), .done(done)
);

// File: tb/cyc_mul_enc_tb.sv
module cyc_mul_enc_tb;
  localparam int CLK_P = 10;
  localparam int K = 11;
  localparam int R = 4;
  localparam int N = K + R;
  localparam logic [R:0] G = 5'b11001;

  logic clk = 0, rst_n = 0, start = 0, din = 0, din_valid = 0;
  logic dout, dout_valid, done;
  int checks = 0, fails = 0;
  logic [N-1:0] got;
  int idx, dones, donepos;

  always #(CLK_P/2) clk = ~clk;

  cyc_mul_enc u_dut (.clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid), .done(done));

  function automatic logic [N-1:0] clmul(input logic [K-1:0] d);
    logic [N-1:0] p = '0;
    for (int i = 0; i <= R; i++) if (G[i]) p = p ^ (N'(d) << i);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (dout_valid) begin
      if (idx < N) got[idx] = dout;
      idx++;
    end
    if (done) begin
      dones++;
      donepos = idx - 1;
    end
  endtask

  task automatic clear_acc();
    got = '0; idx = 0; dones = 0; donepos = -1;
  endtask

  task automatic run_word(input logic [K-1:0] d, input bit gaps, input bit junk, input bit collide);
    start = 1; din_valid = collide; din = 1;
    clear_acc();
    step();
    chk(idx == 0 && dones == 0, "R6/R9 start edge", idx, 0);
    start = 0;
    for (int i = 0; i < K; i++) begin
      if (gaps && (i % 3 == 1)) begin
        din_valid = 0; din = 1;
        step();
      end
      din_valid = 1; din = d[i];
      step();
    end
    din_valid = junk; din = junk;
    for (int i = 0; i < R; i++) step();
    din_valid = 0; din = 0;
    step();
    chk(got == clmul(d), "R2 codeword", got, clmul(d));
    chk(idx == N, "R3/R4 bit count", idx, N);
    chk(dones == 1 && donepos == N - 1, "R5 done position", donepos, N - 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] cw, rem;
    logic [K-1:0] q;
    @(negedge clk);
    chk(dout == 0 && dout_valid == 0 && done == 0, "R1 reset state",
        {dout, dout_valid, done}, 0);
    rst_n = 1;
    clear_acc();
    din_valid = 1; din = 1;
    for (int i = 0; i < 6; i++) step();
    chk(idx == 0 && dones == 0, "R7 idle input ignored", idx, 0);
    din_valid = 0;

    for (int w = 0; w < (1 << K); w++) begin
      logic [K-1:0] d = K'(w);
      run_word(d, d[0] ^ d[3], d[1], d[2]);
    end

    clear_acc();
    din_valid = 1; din = 1;
    for (int i = 0; i < 4; i++) step();
    chk(idx == 0, "R7 idle after done", idx, 0);
    din_valid = 0;

    start = 1; step(); start = 0;
    din_valid = 1; din = 1;
    for (int i = 0; i < 5; i++) step();
    din_valid = 0;
    run_word(11'h5a3, 1'b0, 1'b0, 1'b0);
    chk(got == clmul(11'h5a3), "R6 abort clears chain", got, clmul(11'h5a3));

    cw = 15'b110000100011101;
    rem = cw; q = '0;
    for (int i = N - 1; i >= R; i--)
      if (rem[i]) begin
        rem = rem ^ (N'(G) << (i - R));
        q[i-R] = 1'b1;
      end
    chk(rem == 0, "R2 example divisible", rem, 0);
    run_word(q, 1'b1, 1'b1, 1'b0);
    chk(got == cw, "R2 example codeword", got, cw);
    run_word(11'h7ff, 1'b1, 1'b0, 1'b1);
    chk(got == clmul(11'h7ff), "R8 gaps all ones", got, clmul(11'h7ff));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule